// File: doc/BRIEF.md
# Multiply/Divide Result Reuse Buffer

This block keeps a small direct-mapped memory of recent multiply and divide outcomes, so that a later execution of the same instruction with identical operand values can take its answer without entering the long-latency arithmetic unit. The pipeline queries it at issue, once both source operands are known. It presents the instruction address, the two operand values, a thread number and a flag that marks the instruction as multiply or divide. Hit and result come back combinationally in the same cycle.

When a multiply or divide finishes, the completion path writes the address tag, both operand values and the result into the slot chosen by the address. Each hardware thread has its own bank of slots. A synchronous flush input clears every valid bit in every bank.

Both ports follow valid/ready. The lookup port always accepts, so `lk_ready` is tied high. The update port also always accepts, so `up_ready` is tied high. Neither port ever applies back-pressure. A transfer happens on any cycle in which valid is high. The flag input gates both ports: a request whose flag is low is accepted but has no effect.

Top module: `mdrb_top`

## Requirements
- R1: After reset, and after any cycle with `flush` high, every lookup misses until a new update is written.
- R2: The slot index is PC bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). The tag is PC bits [PC_W-1:IDX_W+2]. The thread id selects the bank.
- R3: A lookup hits only when all of the following hold: `lk_valid` is high, `lk_muldiv` is high, the slot is valid, the stored tag equals the lookup tag, and both stored operands equal the presented operands.
- R4: On a hit, `lk_result` equals the result stored by the last update to that slot. On a miss, `lk_result` is zero.
- R5: An update with `up_valid` and `up_muldiv` both high overwrites the indexed slot of the selected bank. The new contents are visible to lookups from the next cycle onward.
- R6: An update with `up_muldiv` low, or with `up_valid` low, leaves the table unchanged.
- R7: When a lookup and an update address the same slot in the same cycle, the lookup returns the old contents.
- R8: Banks are independent. An update in one thread never causes a hit in another thread.
- R9: `lk_ready` and `up_ready` are always 1. The block never stalls either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears every valid bit |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_muldiv | input | 1 | Lookup instruction is multiply/divide |
| lk_tid | input | TID_W | Lookup thread |
| lk_pc | input | PC_W | Lookup instruction address |
| lk_opa | input | DATA_W | First operand value |
| lk_opb | input | DATA_W | Second operand value |
| lk_hit | output | 1 | Reuse hit |
| lk_result | output | DATA_W | Stored result on hit, else zero |
| up_valid | input | 1 | Update request |
| up_ready | output | 1 | Update accepted (always 1) |
| up_muldiv | input | 1 | Update instruction is multiply/divide |
| up_tid | input | TID_W | Update thread |
| up_pc | input | PC_W | Update instruction address |
| up_opa | input | DATA_W | First operand value |
| up_opb | input | DATA_W | Second operand value |
| up_result | input | DATA_W | Result to record |

## Verification
The bench targets several corner cases, and each one names the failure it would expose:
- Every slot of every bank is filled and read back. A design that indexes with the wrong bits, or that lets banks alias, returns a wrong result or reports a false hit.
- Lookups change only the tag, only operand A, or only operand B. A design that compares just part of the key hits on a stale result.
- A lookup lands in the same cycle as an update to the same slot. A design that bypasses the write shows the new value too early.
- Updates are sent with the multiply/divide flag low, or with valid low, and a flush is applied. Either must leave the stored entries untouched, or, for the flush, leave nothing valid. A design that writes anyway, or that flushes partially, is caught by the follow-up lookups.

// File: rtl/mdrb_pkg.sv
package mdrb_pkg;
  function automatic int clog2i(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/mdrb_bank.sv
module mdrb_bank #(
  parameter int ENTRIES = 1024,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = mdrb_pkg::clog2i(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] rd_res,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_a,
  input  logic [DATA_W-1:0] wr_b,
  input  logic [DATA_W-1:0] wr_res
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_m [ENTRIES];
  logic [DATA_W-1:0]  a_m   [ENTRIES];
  logic [DATA_W-1:0]  b_m   [ENTRIES];
  logic [DATA_W-1:0]  res_m [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[wr_idx] <= wr_tag;
      a_m[wr_idx]   <= wr_a;
      b_m[wr_idx]   <= wr_b;
      res_m[wr_idx] <= wr_res;
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_tag = tag_m[rd_idx];
  assign rd_a   = a_m[rd_idx];
  assign rd_b   = b_m[rd_idx];
  assign rd_res = res_m[rd_idx];

  // R5
  wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> vld_q[$past(wr_idx)]);
  // R1
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
endmodule

// File: rtl/mdrb_match.sv
module mdrb_match #(
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              req,
  input  logic              e_vld,
  input  logic [TAG_W-1:0]  e_tag,
  input  logic [DATA_W-1:0] e_a,
  input  logic [DATA_W-1:0] e_b,
  input  logic [DATA_W-1:0] e_res,
  input  logic [TAG_W-1:0]  q_tag,
  input  logic [DATA_W-1:0] q_a,
  input  logic [DATA_W-1:0] q_b,
  output logic              hit,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    hit = req && e_vld && (e_tag == q_tag) && (e_a == q_a) && (e_b == q_b);
    res = hit ? e_res : '0;
  end
endmodule

// File: rtl/mdrb_top.sv
module mdrb_top #(
  parameter int ENTRIES = 1024,
  parameter int THREADS = 2,
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = mdrb_pkg::clog2i(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - 2,
  localparam int TID_W  = (THREADS > 1) ? mdrb_pkg::clog2i(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic              lk_muldiv,
  input  logic [TID_W-1:0]  lk_tid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [DATA_W-1:0] lk_opa,
  input  logic [DATA_W-1:0] lk_opb,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_result,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_muldiv,
  input  logic [TID_W-1:0]  up_tid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [DATA_W-1:0] up_opa,
  input  logic [DATA_W-1:0] up_opb,
  input  logic [DATA_W-1:0] up_result
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             up_fire;

  assign lk_ready = 1'b1;
  assign up_ready = 1'b1;
  assign lk_idx   = lk_pc[IDX_W+1:2];
  assign lk_tag   = lk_pc[PC_W-1:IDX_W+2];
  assign up_idx   = up_pc[IDX_W+1:2];
  assign up_tag   = up_pc[PC_W-1:IDX_W+2];
  assign up_fire  = up_valid && up_muldiv;

  logic              b_vld [THREADS];
  logic [TAG_W-1:0]  b_tag [THREADS];
  logic [DATA_W-1:0] b_a   [THREADS];
  logic [DATA_W-1:0] b_b   [THREADS];
  logic [DATA_W-1:0] b_res [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_bank
    logic wr_en_t;
    assign wr_en_t = up_fire && (int'(up_tid) == t);
    mdrb_bank #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .rd_idx(lk_idx), .rd_vld(b_vld[t]), .rd_tag(b_tag[t]),
      .rd_a(b_a[t]), .rd_b(b_b[t]), .rd_res(b_res[t]),
      .wr_en(wr_en_t), .wr_idx(up_idx), .wr_tag(up_tag),
      .wr_a(up_opa), .wr_b(up_opb), .wr_res(up_result));
  end

  logic              s_vld;
  logic [TAG_W-1:0]  s_tag;
  logic [DATA_W-1:0] s_a, s_b, s_res;
  always_comb begin
    s_vld = 1'b0; s_tag = '0; s_a = '0; s_b = '0; s_res = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (int'(lk_tid) == t) begin
        s_vld = b_vld[t]; s_tag = b_tag[t];
        s_a = b_a[t]; s_b = b_b[t]; s_res = b_res[t];
      end
    end
  end

  mdrb_match #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
    .req(lk_valid && lk_muldiv), .e_vld(s_vld), .e_tag(s_tag),
    .e_a(s_a), .e_b(s_b), .e_res(s_res),
    .q_tag(lk_tag), .q_a(lk_opa), .q_b(lk_opb),
    .hit(lk_hit), .res(lk_result));

  // R3
  hit_needs_muldiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && lk_muldiv));
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_result == '0));
  // R1
  no_hit_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lk_hit);
  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready && up_ready);
endmodule

// File: tb/mdrb_top_bench.sv
module mdrb_top_bench;
  localparam int ENT = 16, THR = 2, PCW = 16, DW = 16, IW = 4;
  logic clk = 0, rst_n = 0, flush = 0;
  logic lk_valid = 0, lk_muldiv = 0, up_valid = 0, up_muldiv = 0;
  logic [0:0] lk_tid = 0, up_tid = 0;
  logic [PCW-1:0] lk_pc = 0, up_pc = 0;
  logic [DW-1:0] lk_opa = 0, lk_opb = 0, up_opa = 0, up_opb = 0, up_result = 0;
  logic lk_ready, up_ready, lk_hit;
  logic [DW-1:0] lk_result;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  mdrb_top #(.ENTRIES(ENT), .THREADS(THR), .PC_W(PCW), .DATA_W(DW)) u_mdrb_top (
    .clk, .rst_n, .flush, .lk_valid, .lk_ready, .lk_muldiv, .lk_tid, .lk_pc,
    .lk_opa, .lk_opb, .lk_hit, .lk_result, .up_valid, .up_ready, .up_muldiv,
    .up_tid, .up_pc, .up_opa, .up_opb, .up_result);

  function automatic logic [PCW-1:0] pcof(int tag, int idx);
    return PCW'((tag << (IW + 2)) | (idx << 2));
  endfunction
  function automatic logic [DW-1:0] resof(int t, int i, int s);
    return DW'(t * 1000 + i * 37 + s * 5 + 11);
  endfunction

  task automatic chk(string r, logic eh, logic [DW-1:0] er);
    tests++;
    if (lk_hit !== eh || lk_result !== er) begin
      fails++;
      $display("FAIL %s hit=%0b res=%0h expected hit=%0b res=%0h", r, lk_hit, lk_result, eh, er);
    end
  endtask

  task automatic look(int t, logic [PCW-1:0] pc, logic [DW-1:0] a, logic [DW-1:0] b, logic md);
    lk_valid = 1; lk_muldiv = md; lk_tid = 1'(t); lk_pc = pc; lk_opa = a; lk_opb = b;
    #1;
  endtask

  task automatic upd(int t, logic [PCW-1:0] pc, logic [DW-1:0] a, logic [DW-1:0] b,
                     logic [DW-1:0] r, logic md, logic v);
    up_valid = v; up_muldiv = md; up_tid = 1'(t); up_pc = pc;
    up_opa = a; up_opb = b; up_result = r;
    @(posedge clk); #1;
    up_valid = 0; up_muldiv = 0;
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog R1 expired actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 ready
    tests++;
    if (!(lk_ready && up_ready)) begin
      fails++;
      $display("FAIL R9 ready=%0b%0b expected=11", lk_ready, up_ready);
    end
    // R1 reset: all miss
    for (int t = 0; t < THR; t++)
      for (int i = 0; i < ENT; i++) begin
        look(t, pcof(3, i), 0, 0, 1);
        chk("R1", 0, 0);
      end
    // R2/R5 fill every slot, bank-specific values
    for (int t = 0; t < THR; t++)
      for (int i = 0; i < ENT; i++)
        upd(t, pcof(t + 5, i), DW'(i), DW'(t + 7), resof(t, i, 0), 1, 1);
    for (int t = 0; t < THR; t++)
      for (int i = 0; i < ENT; i++) begin
        look(t, pcof(t + 5, i), DW'(i), DW'(t + 7), 1);
        chk("R2 R5 R4", 1, resof(t, i, 0));
        // R8 other bank's key misses
        look(1 - t, pcof(t + 5, i), DW'(i), DW'(t + 7), 1);
        chk("R8", 0, 0);
        // R3 partial matches
        look(t, pcof(t + 9, i), DW'(i), DW'(t + 7), 1);
        chk("R3 tag", 0, 0);
        look(t, pcof(t + 5, i), DW'(i) ^ 16'h0100, DW'(t + 7), 1);
        chk("R3 opa", 0, 0);
        look(t, pcof(t + 5, i), DW'(i), DW'(t + 7) ^ 16'h8000, 1);
        chk("R3 opb", 0, 0);
        look(t, pcof(t + 5, i), DW'(i), DW'(t + 7), 0);
        chk("R3 muldiv", 0, 0);
        lk_valid = 0; #1;
        chk("R3 valid", 0, 0);
      end
    // R6 non-muldiv and invalid updates do nothing
    upd(0, pcof(5, 3), 16'h3, 16'h7, 16'hBEEF, 0, 1);
    upd(0, pcof(5, 4), 16'h4, 16'h7, 16'hBEEF, 1, 0);
    look(0, pcof(5, 3), 16'h3, 16'h7, 1);
    chk("R6 flag", 1, resof(0, 3, 0));
    look(0, pcof(5, 4), 16'h4, 16'h7, 1);
    chk("R6 valid", 1, resof(0, 4, 0));
    // R7 same-cycle read sees old, next cycle sees new
    look(1, pcof(6, 2), 16'h2, 16'h8, 1);
    up_valid = 1; up_muldiv = 1; up_tid = 1; up_pc = pcof(6, 2);
    up_opa = 16'h2; up_opb = 16'h8; up_result = 16'h1234;
    #1 chk("R7 old", 1, resof(1, 2, 0));
    @(posedge clk); #1;
    up_valid = 0; up_muldiv = 0; #1;
    chk("R5 new", 1, 16'h1234);
    // R1 flush
    flush = 1; @(posedge clk); #1 flush = 0;
    for (int t = 0; t < THR; t++)
      for (int i = 0; i < ENT; i++) begin
        look(t, pcof(t + 5, i), DW'(i), DW'(t + 7), 1);
        chk("R1 flush", 0, 0);
      end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule